// File: doc/BRIEF.md
# Trap Vector and Cause Unit

This unit decides where a machine-mode hart continues when it takes a trap. A trap arrives as a 32-bit packed descriptor. The unit combines it with a trap-vector register to produce the next program counter. For direct and vectored modes the result is ready in the cycle the trap is accepted. When the table option is built in and an interrupt hits mode 3, the handler address is not computed. It is fetched as one word from memory, at the address held in a vector-table base register, and the trap completes when that word comes back.

The unit holds three software-visible registers: the trap vector, the cause and the table base. A write to the cause register keeps only the interrupt flag and the code bits the configuration supports. A read of the trap vector hides bit 1 unless the table option is built in. Every accepted trap raises a one-cycle pulse telling the hart to clear its global machine interrupt enable.

Top module: `trap_vector_unit`

## Requirements
- R1: A trap is accepted only when `trap_valid` is high and descriptor bit 31 (active) is set. Bits 30:16 carry the cause and bits 15:0 an identifier, where a nonzero identifier means an interrupt. `gie_clear` pulses high in the accept cycle only.
- R2: The vector register's bits 1:0 are the mode, and the base is the register with those two bits zeroed. In mode 0 and mode 2, every trap goes to the base, and so does every exception (identifier 0) in any mode.
- R3: When vector bit 0 is set and the trap is an interrupt, the next PC is base + 4 × cause. Without the table option this also covers mode 3.
- R4: With the table option (CLIC_EN=1), an interrupt in mode 3 causes a memory read. `mem_req_valid` rises in the cycle after entry and stays high, with `mem_req_addr` equal to the table base, until `mem_req_ready`. After that, a `mem_rsp_valid` without error gives `trap_done` with `next_pc` equal to `mem_rsp_data` in the same cycle.
- R5: If the table response carries `mem_rsp_err`, `next_pc` equals the `cur_pc` captured at trap entry.
- R6: While a table read is outstanding, no new trap is accepted: `gie_clear` stays low and no `trap_done` appears until the response.
- R7: A read of the vector register (`csr_sel`=0) returns it with bit 1 cleared when CLIC_EN=0, and unmodified when CLIC_EN=1.
- R8: A write to the cause register (`csr_sel`=1) keeps bit XLEN-1 and the low 12 bits with CLIC_EN=1, or the low 4 bits with CLIC_EN=0. All other bits read back as zero. The table base is at `csr_sel`=2.
- R9: For traps that need no table read, `trap_done` pulses for one cycle in the accept cycle, together with `gie_clear`.
- R10: A synchronous active-low reset clears the vector, cause and table-base registers to zero and returns the fetch logic to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap descriptor presented this cycle |
| trap_desc | input | 32 | Packed descriptor: active, cause, identifier |
| cur_pc | input | XLEN | PC of the trapping instruction |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 vector, 1 cause, 2 table base |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Read data of the selected register |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Request accepted by memory |
| mem_req_addr | output | XLEN | Table read address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | XLEN | Read response word |
| mem_rsp_err | input | 1 | Read response is an error |
| next_pc | output | XLEN | Resume address, valid with trap_done |
| trap_done | output | 1 | One-cycle pulse: next_pc is valid |
| gie_clear | output | 1 | One-cycle pulse: clear global interrupt enable |

## Verification
On every cycle, the checker enforces four things: the request holds with a stable address until accepted, no entry happens while a fetch is outstanding, a response always completes the trap, and an immediate completion always coincides with entry. It also checks that the cause register never holds bits outside its mask and, without the table option, that a vector read never shows bit 1. The actual target addresses can only be shown by the bench's scenarios: base, base plus scaled cause, the fetched word, and the fall-back to the trapping PC on an error. Those scenarios also cover the read-back values of masked registers and the clearing by reset. Two instances, one per option setting, receive the same stimulus.

// File: rtl/tvu_pkg.sv
// Shared types of the trap vector unit.
// Assumes a 32-bit descriptor layout fixed by the trap source.
package tvu_pkg;
    typedef enum logic [1:0] {
        FETCH_IDLE = 2'd0,
        FETCH_REQ  = 2'd1,
        FETCH_WAIT = 2'd2
    } fetch_state_e;

    typedef enum logic [1:0] {
        SEL_TVEC  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_TBASE = 2'd2
    } csr_sel_e;

    typedef struct packed {
        logic        active;
        logic [14:0] cause;
        logic [15:0] ident;
    } trap_desc_t;
endpackage

// File: rtl/tvu_csr.sv
// Vector, cause and table-base registers with write and read masking.
// Assumes one access per cycle; the read port is combinational.
module tvu_csr #(
    parameter int XLEN    = 32,
    parameter bit CLIC_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] tvec_q,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] tbase_q
);
    import tvu_pkg::*;

    localparam int CODE_BITS = CLIC_EN ? 12 : 4;
    localparam logic [XLEN-1:0] CAUSE_MASK =
        {1'b1, {(XLEN-1-CODE_BITS){1'b0}}, {CODE_BITS{1'b1}}};

    csr_sel_e sel_e;
    assign sel_e = csr_sel_e'(sel);

    // Register update with masking of the cause value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvec_q  <= '0;
            cause_q <= '0;
            tbase_q <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_TVEC:  tvec_q  <= wdata;
                SEL_CAUSE: cause_q <= wdata & CAUSE_MASK;
                SEL_TBASE: tbase_q <= wdata;
                default:   ;
            endcase
        end
    end

    // Read mux; bit 1 of the vector is hidden without the table option.
    always_comb begin
        case (sel_e)
            SEL_TVEC:  rdata = CLIC_EN ? tvec_q : (tvec_q & ~XLEN'(2));
            SEL_CAUSE: rdata = cause_q;
            SEL_TBASE: rdata = tbase_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tvu_vector_calc.sv
// Computes the direct or vectored target and whether a table read is needed.
// Assumes the cause fits in 15 bits, so 4*cause fits in XLEN >= 17.
module tvu_vector_calc #(
    parameter int XLEN    = 32,
    parameter bit CLIC_EN = 1'b1
) (
    input  logic [XLEN-1:0] tvec,
    input  logic [14:0]     cause,
    input  logic            is_irq,
    output logic [XLEN-1:0] target,
    output logic            use_table
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Base address and scaled cause offset for vectored interrupts.
    always_comb begin
        base   = tvec & ~XLEN'(3);
        offset = (is_irq && tvec[0]) ? XLEN'({cause, 2'b00}) : '0;
        target = base + offset;
    end

    generate
        if (CLIC_EN) begin : g_table
            // Table path: interrupt with both mode bits set.
            always_comb use_table = is_irq && (tvec[1:0] == 2'b11);
        end else begin : g_no_table
            // No table path without the option.
            always_comb use_table = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tvu_fetch.sv
// Single-word handler fetch: request until ready, then wait for a response.
// Assumes the response never arrives in the same cycle as request acceptance.
module tvu_fetch #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] table_addr,
    input  logic [XLEN-1:0] entry_pc,
    output logic            busy,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [XLEN-1:0] req_addr,
    input  logic            rsp_valid,
    input  logic [XLEN-1:0] rsp_data,
    input  logic            rsp_err,
    output logic            done,
    output logic [XLEN-1:0] done_pc
);
    import tvu_pkg::*;

    fetch_state_e    state_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] pc_q;

    // Sequencing of the fetch and capture of address and entry PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FETCH_IDLE;
            addr_q  <= '0;
            pc_q    <= '0;
        end else begin
            case (state_q)
                FETCH_IDLE: if (start) begin
                    state_q <= FETCH_REQ;
                    addr_q  <= table_addr;
                    pc_q    <= entry_pc;
                end
                FETCH_REQ:  if (req_ready) state_q <= FETCH_WAIT;
                FETCH_WAIT: if (rsp_valid) state_q <= FETCH_IDLE;
                default:    state_q <= FETCH_IDLE;
            endcase
        end
    end

    // Handshake outputs and completion result.
    always_comb begin
        busy      = (state_q != FETCH_IDLE);
        req_valid = (state_q == FETCH_REQ);
        req_addr  = addr_q;
        done      = (state_q == FETCH_WAIT) && rsp_valid;
        done_pc   = rsp_err ? pc_q : rsp_data;
    end
endmodule

// File: rtl/trap_vector_unit.sv
// Trap entry: decodes the descriptor, picks the target or fetches it from a table.
// Assumes the hart holds off its own state until trap_done.
module trap_vector_unit #(
    parameter int XLEN    = 32,
    parameter bit CLIC_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [31:0]     trap_desc,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic [XLEN-1:0] next_pc,
    output logic            trap_done,
    output logic            gie_clear
);
    import tvu_pkg::*;

    trap_desc_t      desc;
    logic [XLEN-1:0] tvec_q, cause_q, tbase_q;
    logic [XLEN-1:0] target, fetch_pc;
    logic            is_irq, use_table, accept, fetch_busy, fetch_done;

    assign desc = trap_desc_t'(trap_desc);

    tvu_csr #(.XLEN(XLEN), .CLIC_EN(CLIC_EN)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .sel(csr_sel),
        .wdata(csr_wdata), .rdata(csr_rdata),
        .tvec_q(tvec_q), .cause_q(cause_q), .tbase_q(tbase_q)
    );

    tvu_vector_calc #(.XLEN(XLEN), .CLIC_EN(CLIC_EN)) u_calc (
        .tvec(tvec_q), .cause(desc.cause), .is_irq(is_irq),
        .target(target), .use_table(use_table)
    );

    tvu_fetch #(.XLEN(XLEN)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(accept && use_table),
        .table_addr(tbase_q), .entry_pc(cur_pc), .busy(fetch_busy),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready),
        .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid),
        .rsp_data(mem_rsp_data), .rsp_err(mem_rsp_err),
        .done(fetch_done), .done_pc(fetch_pc)
    );

    // Trap acceptance and selection of the result source.
    always_comb begin
        is_irq    = (desc.ident != '0);
        accept    = trap_valid && desc.active && !fetch_busy;
        gie_clear = accept;
        trap_done = (accept && !use_table) || fetch_done;
        next_pc   = fetch_done ? fetch_pc : target;
    end
endmodule

// File: rtl/tvu_checker.sv
// Protocol and state checks for trap_vector_unit, attached by bind.
// Assumes the same parameters as the bound instance.
module tvu_checker #(
    parameter int XLEN    = 32,
    parameter bit CLIC_EN = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      csr_sel,
    input logic [XLEN-1:0] csr_rdata,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            trap_done,
    input logic            gie_clear,
    input logic            fetch_busy,
    input logic [XLEN-1:0] cause_q
);
    localparam int CODE_BITS = CLIC_EN ? 12 : 4;
    localparam logic [XLEN-1:0] KEEP =
        {1'b1, {(XLEN-1-CODE_BITS){1'b0}}, {CODE_BITS{1'b1}}};

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_rsp_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy && !mem_req_valid && mem_rsp_valid |-> trap_done);

    p_no_entry_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy |-> !gie_clear);

    p_done_at_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done && !fetch_busy |-> gie_clear);

    p_cause_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~KEEP) == '0);

    generate
        if (!CLIC_EN) begin : g_tvec_hide
            p_tvec_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
                csr_sel == 2'd0 |-> !csr_rdata[1]);
        end
    endgenerate
endmodule

bind trap_vector_unit tvu_checker #(.XLEN(XLEN), .CLIC_EN(CLIC_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_rdata(csr_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .trap_done(trap_done), .gie_clear(gie_clear),
    .fetch_busy(fetch_busy), .cause_q(cause_q)
);

// File: tb/sim_trap_vector_unit.sv
// Directed bench: u0 built with the table option, u1 without; both get the same inputs.
module sim_trap_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [31:0] trap_desc = '0;
    logic [31:0] cur_pc = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    logic [31:0] rd0, rd1, addr0, addr1, npc0, npc1;
    logic        req0, req1, done0, done1, gie0, gie1;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trap_vector_unit #(.XLEN(32), .CLIC_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_desc(trap_desc),
        .cur_pc(cur_pc), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(rd0), .mem_req_valid(req0), .mem_req_ready(mem_req_ready),
        .mem_req_addr(addr0), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .next_pc(npc0), .trap_done(done0), .gie_clear(gie0)
    );

    trap_vector_unit #(.XLEN(32), .CLIC_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_desc(trap_desc),
        .cur_pc(cur_pc), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(rd1), .mem_req_valid(req1), .mem_req_ready(mem_req_ready),
        .mem_req_addr(addr1), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .next_pc(npc1), .trap_done(done1), .gie_clear(gie1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit act, input int cause, input int id);
        return {act, 15'(cause), 16'(id)};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel);
        csr_sel = sel;
        #1;
    endtask

    // Present a trap at a negedge; outputs are sampled 1 ns later.
    task automatic present(input logic [31:0] d, input logic [31:0] pc);
        @(negedge clk);
        trap_valid = 1'b1; trap_desc = d; cur_pc = pc;
        #1;
    endtask

    task automatic t_reset_clears;
        wr(2'd0, 32'h1234_5673);
        wr(2'd1, 32'h8000_0003);
        wr(2'd2, 32'h0000_9000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0); check("R10 tvec zero", rd0, 32'h0);
        rd(2'd1); check("R10 cause zero", rd0, 32'h0);
        rd(2'd2); check("R10 tbase zero", rd0, 32'h0);
        check("R10 idle no request", {31'h0, req0}, 32'h0);
    endtask

    task automatic t_csr_masks;
        wr(2'd0, 32'h0000_1003);
        rd(2'd0);
        check("R7 tvec read with table option", rd0, 32'h0000_1003);
        check("R7 tvec read without table option", rd1, 32'h0000_1001);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1);
        check("R8 cause mask 12 bits", rd0, 32'h8000_0FFF);
        check("R8 cause mask 4 bits", rd1, 32'h8000_000F);
    endtask

    task automatic t_direct;
        wr(2'd0, 32'h0000_2000);
        present(mk(1'b0, 5, 7), 32'h100);
        check("R1 inactive not taken", {30'h0, gie0, done0}, 32'h0);
        present(mk(1'b1, 5, 7), 32'h100);
        check("R1 gie_clear at entry", {31'h0, gie0}, 32'h1);
        check("R9 done at entry", {31'h0, done0}, 32'h1);
        check("R2 direct target", npc0, 32'h0000_2000);
        @(negedge clk); trap_valid = 1'b0; #1;
        check("R9 done one cycle", {30'h0, gie0, done0}, 32'h0);
    endtask

    task automatic t_vectored;
        wr(2'd0, 32'h0000_2001);
        present(mk(1'b1, 5, 7), 32'h100);
        check("R3 vectored interrupt", npc0, 32'h0000_2014);
        present(mk(1'b1, 2, 0), 32'h100);
        check("R2 vectored exception to base", npc0, 32'h0000_2000);
        wr(2'd0, 32'h0000_2002);
        present(mk(1'b1, 5, 7), 32'h100);
        check("R2 mode 2 to base", npc0, 32'h0000_2000);
        @(negedge clk); trap_valid = 1'b0;
    endtask

    task automatic t_table;
        wr(2'd0, 32'h0000_3003);
        wr(2'd2, 32'h0000_8000);
        present(mk(1'b1, 3, 1), 32'h500);
        check("R4 entry pulse with table", {31'h0, gie0}, 32'h1);
        check("R4 no done at entry", {31'h0, done0}, 32'h0);
        check("R3 mode 3 without option", npc1, 32'h0000_300C);
        check("R9 no-option done at entry", {31'h0, done1}, 32'h1);
        trap_desc = mk(1'b1, 4, 2);
        @(negedge clk); #1;
        check("R4 request raised", {31'h0, req0}, 32'h1);
        check("R4 request address", addr0, 32'h0000_8000);
        check("R6 no entry while busy", {30'h0, gie0, done0}, 32'h0);
        trap_valid = 1'b0;
        @(negedge clk); #1;
        check("R4 request held", {31'h0, req0}, 32'h1);
        check("R4 address held", addr0, 32'h0000_8000);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        #1;
        check("R4 request dropped after ready", {31'h0, req0}, 32'h0);
        check("R6 no done before response", {31'h0, done0}, 32'h0);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h000A_BCD0; mem_rsp_err = 1'b0;
        #1;
        check("R4 done on response", {31'h0, done0}, 32'h1);
        check("R4 fetched target", npc0, 32'h000A_BCD0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        check("R4 done one cycle", {31'h0, done0}, 32'h0);
    endtask

    task automatic t_table_error;
        present(mk(1'b1, 9, 3), 32'h0000_0777);
        mem_req_ready = 1'b1;
        @(negedge clk);
        trap_valid = 1'b0;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_0000; mem_rsp_err = 1'b1;
        #1;
        check("R5 done on error", {31'h0, done0}, 32'h1);
        check("R5 error keeps trapping pc", npc0, 32'h0000_0777);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    endtask

    task automatic t_table_exception;
        present(mk(1'b1, 6, 0), 32'h100);
        check("R2 mode 3 exception to base", npc0, 32'h0000_3000);
        check("R9 exception done at entry", {30'h0, gie0, done0}, 32'h3);
        @(negedge clk); trap_valid = 1'b0; #1;
        check("R2 no request for exception", {31'h0, req0}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_clears();
        t_csr_masks();
        t_direct();
        t_vectored();
        t_table();
        t_table_error();
        t_table_exception();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule